// File: doc/BRIEF.md
# Tiled Accumulator Address Generator

This block produces the sequence of SRAM word addresses used to fetch preload values into an accumulator buffer and to store finished results back out. The walk has four nested levels. From innermost to outermost they are: a position along the merged x/y axis inside the tile, a channel inside the tile, the tile's position on the x/y plane, and the tile's output-channel group. Each word address is the sum of the four counter values. Alongside each address the block produces a per-slot element mask. The mask tells the packing logic which element slots of the word fall inside the tile.

Reads and writes visit the same positions inside a tile, but they work on different tiles. For that reason the two inner counters are a single shared copy. Each of the two tiling counters stores one position for the read stream and one for the write stream. The two stored positions share one adder and one compare path, chosen through a context select. Only one transaction is issued per cycle, so a single-port SRAM is enough. The scheduler drives a start strobe, a step strobe and the context select. It changes context only at tile boundaries or right after a start. It reads the tile-end, tensor-end and done flags to pace the exchange.

Top module: `tile_addr_gen`

## Requirements
- R1: The x counter starts at 0 and steps by WORD_WIDTH on each accepted step. It returns to 0 on the step where the current value plus WORD_WIDTH is at least cfg_tile_x_i. `addr_o` is the sum of the x, channel, tile-xy and tile-channel counter values of the selected context, truncated to ADDR_W bits.
- R2: The channel-in-tile counter advances only when the x counter wraps. It steps by cfg_tensor_xy_i and wraps at cfg_tensor_xy_i*cfg_tile_ch_i.
- R3: The tile-xy counter advances only when both inner counters wrap. It steps by cfg_move_xy_i and wraps at cfg_tensor_xy_i.
- R4: The tile-channel counter advances only when the three inner counters wrap. It steps by cfg_tensor_xy_i*cfg_move_k_i and wraps at cfg_tensor_xy_i*cfg_tensor_k_i.
- R5: ctx_sel_i = 0 selects the read context and 1 selects the write context. A step or start in one context leaves the other context's tiling positions unchanged. The two inner counters are common to both contexts.
- R6: Bit i of `mask_o` is 1 exactly when x + i < cfg_tile_x_i, where x is the current x counter value. This clears the slots past the tile edge on the last word of a row.
- R7: `tile_last_o` is 1 when the current word is the last word of the tile, meaning both inner counters are at their final value. `tensor_last_o` is 1 when, in addition, both tiling counters of the selected context are at their final value.
- R8: Each context has its own done flag, shown on `done_o` for the selected context. The flag is set by a step taken on the tensor's last word. That step also returns the context to address 0. The flag stays set through further steps until a start is issued in that context.
- R9: `start_i` clears the inner counters, the selected context's tiling counters and its done flag. When `start_i` and `step_i` are high in the same cycle, the start wins and no step takes place.
- R10: While reset is high and after it is released, all counters and both done flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Restart the selected context at the tensor origin |
| step_i | input | 1 | Advance the selected context by one word |
| ctx_sel_i | input | 1 | Context select: 0 read, 1 write |
| cfg_tensor_xy_i | input | ADDR_W | Merged x*y extent of the tensor plane |
| cfg_tensor_k_i | input | ADDR_W | Number of output channels |
| cfg_tile_ch_i | input | ADDR_W | Channels per tile |
| cfg_tile_x_i | input | ADDR_W | Tile extent along the merged x/y axis |
| cfg_move_xy_i | input | ADDR_W | Tile step on the x/y plane |
| cfg_move_k_i | input | ADDR_W | Tile step in channels |
| addr_o | output | ADDR_W | SRAM word address |
| mask_o | output | WORD_WIDTH | Element slots of interest in the word |
| tile_last_o | output | 1 | Current word ends the tile |
| tensor_last_o | output | 1 | Current word ends the tensor |
| done_o | output | 1 | Selected context has completed the tensor |

## Verification
All results are combinational functions of the registered counters and the context select. A change of `ctx_sel_i` or of the configuration therefore shows on the outputs in the same cycle. A start or step sampled at a rising edge shows right after that edge. The bench drives its inputs on the falling edge and compares every output one time unit later against a behavioural model. That model lists each context's expected sequence in nested loops and keeps one list index per context, advancing the index only after the rising edge that consumes the strobe. The scheduler pattern interleaves whole read and write tiles. It also places a start and a step in the same cycle, steps a context that is already done, and idles between strobes.

// File: rtl/tag_pkg.sv
package tag_pkg;

    localparam int unsigned ADDR_W = 16;

    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic {
        CTX_RD = 1'b0,
        CTX_WR = 1'b1
    } ctx_e;

    // next value of a stepping counter and whether it wraps instead
    typedef struct packed {
        addr_t nxt;
        logic  wrap;
    } adv_t;

    // wrap condition of each loop level, innermost first in the name list
    typedef struct packed {
        logic x;
        logic k;
        logic txy;
        logic tk;
    } wrap_t;

    function automatic adv_t advance(addr_t cur, addr_t stride, addr_t limit);
        logic [ADDR_W:0] sum;
        adv_t r;
        sum    = {1'b0, cur} + {1'b0, stride};
        r.wrap = (sum >= {1'b0, limit});
        r.nxt  = r.wrap ? '0 : sum[ADDR_W-1:0];
        return r;
    endfunction

endpackage

// File: rtl/tag_inner_ctr.sv
module tag_inner_ctr
    import tag_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clr_i,
    input  logic  inc_i,
    input  addr_t stride_i,
    input  addr_t limit_i,
    output addr_t val_o,
    output logic  wrap_o
);

    addr_t val_q;
    adv_t  adv;

    always_comb adv = advance(val_q, stride_i, limit_i);

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            val_q <= '0;
        end else if (inc_i) begin
            val_q <= adv.nxt;
        end
    end

    assign val_o  = val_q;
    assign wrap_o = adv.wrap;

endmodule

// File: rtl/tag_dual_ctr.sv
module tag_dual_ctr
    import tag_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  ctx_e            sel_i,
    input  logic            clr_i,
    input  logic            inc_i,
    input  addr_t           stride_i,
    input  addr_t           limit_i,
    output addr_t           val_o,
    output logic            wrap_o,
    output addr_t [1:0]     ctx_o
);

    addr_t [1:0] ctx_q;
    addr_t       cur;
    adv_t        adv;

    // one adder and compare, shared by both stored contexts
    always_comb begin
        cur = ctx_q[sel_i];
        adv = advance(cur, stride_i, limit_i);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx_q <= '0;
        end else if (clr_i) begin
            ctx_q[sel_i] <= '0;
        end else if (inc_i) begin
            ctx_q[sel_i] <= adv.nxt;
        end
    end

    assign val_o  = cur;
    assign wrap_o = adv.wrap;
    assign ctx_o  = ctx_q;

endmodule

// File: rtl/tag_mask_gen.sv
module tag_mask_gen
    import tag_pkg::*;
#(
    parameter int unsigned WORD_WIDTH = 4
) (
    input  addr_t                 x_i,
    input  addr_t                 tile_x_i,
    output logic [WORD_WIDTH-1:0] mask_o
);

    localparam int unsigned SW = ADDR_W + 1;

    for (genvar i = 0; i < WORD_WIDTH; i++) begin : g_slot
        assign mask_o[i] = ({1'b0, x_i} + SW'(i)) < {1'b0, tile_x_i};
    end

endmodule

// File: rtl/tile_addr_gen.sv
module tile_addr_gen
    import tag_pkg::*;
#(
    parameter int unsigned WORD_WIDTH = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start_i,
    input  logic                  step_i,
    input  logic                  ctx_sel_i,
    input  logic [ADDR_W-1:0]     cfg_tensor_xy_i,
    input  logic [ADDR_W-1:0]     cfg_tensor_k_i,
    input  logic [ADDR_W-1:0]     cfg_tile_ch_i,
    input  logic [ADDR_W-1:0]     cfg_tile_x_i,
    input  logic [ADDR_W-1:0]     cfg_move_xy_i,
    input  logic [ADDR_W-1:0]     cfg_move_k_i,
    output logic [ADDR_W-1:0]     addr_o,
    output logic [WORD_WIDTH-1:0] mask_o,
    output logic                  tile_last_o,
    output logic                  tensor_last_o,
    output logic                  done_o
);

    localparam addr_t X_STRIDE = addr_t'(WORD_WIDTH);

    ctx_e        sel;
    wrap_t       wrap;
    addr_t       x_val, k_val, txy_val, tk_val;
    addr_t       k_limit, tk_stride, tk_limit;
    addr_t [1:0] txy_ctx, tk_ctx;
    logic        inc_x, inc_k, inc_txy, inc_tk;
    logic [1:0]  done_q;

    assign sel       = ctx_e'(ctx_sel_i);
    assign k_limit   = cfg_tensor_xy_i * cfg_tile_ch_i;
    assign tk_stride = cfg_tensor_xy_i * cfg_move_k_i;
    assign tk_limit  = cfg_tensor_xy_i * cfg_tensor_k_i;

    // carry chain: each level advances when all inner levels wrap
    assign inc_x   = step_i && !start_i;
    assign inc_k   = inc_x   && wrap.x;
    assign inc_txy = inc_k   && wrap.k;
    assign inc_tk  = inc_txy && wrap.txy;

    tag_inner_ctr i_x_ctr (
        .clk(clk), .rst(rst), .clr_i(start_i), .inc_i(inc_x),
        .stride_i(X_STRIDE), .limit_i(cfg_tile_x_i),
        .val_o(x_val), .wrap_o(wrap.x)
    );

    tag_inner_ctr i_k_ctr (
        .clk(clk), .rst(rst), .clr_i(start_i), .inc_i(inc_k),
        .stride_i(cfg_tensor_xy_i), .limit_i(k_limit),
        .val_o(k_val), .wrap_o(wrap.k)
    );

    tag_dual_ctr i_txy_ctr (
        .clk(clk), .rst(rst), .sel_i(sel), .clr_i(start_i), .inc_i(inc_txy),
        .stride_i(cfg_move_xy_i), .limit_i(cfg_tensor_xy_i),
        .val_o(txy_val), .wrap_o(wrap.txy), .ctx_o(txy_ctx)
    );

    tag_dual_ctr i_tk_ctr (
        .clk(clk), .rst(rst), .sel_i(sel), .clr_i(start_i), .inc_i(inc_tk),
        .stride_i(tk_stride), .limit_i(tk_limit),
        .val_o(tk_val), .wrap_o(wrap.tk), .ctx_o(tk_ctx)
    );

    tag_mask_gen #(.WORD_WIDTH(WORD_WIDTH)) i_mask (
        .x_i(x_val), .tile_x_i(cfg_tile_x_i), .mask_o(mask_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= '0;
        end else if (start_i) begin
            done_q[sel] <= 1'b0;
        end else if (inc_tk && wrap.tk) begin
            done_q[sel] <= 1'b1;
        end
    end

    assign addr_o        = x_val + k_val + txy_val + tk_val;
    assign tile_last_o   = wrap.x && wrap.k;
    assign tensor_last_o = tile_last_o && wrap.txy && wrap.tk;
    assign done_o        = done_q[sel];

endmodule

// File: rtl/tag_addr_chk.sv
module tag_addr_chk
    import tag_pkg::*;
#(
    parameter int unsigned WORD_WIDTH = 4
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  start_i,
    input logic                  step_i,
    input logic                  ctx_sel_i,
    input logic [ADDR_W-1:0]     cfg_tile_x_i,
    input logic [ADDR_W-1:0]     addr_o,
    input logic [WORD_WIDTH-1:0] mask_o,
    input logic                  tile_last_o,
    input logic                  tensor_last_o,
    input logic                  done_o,
    input addr_t                 x_val,
    input addr_t                 k_val,
    input logic                  wrap_x,
    input addr_t                 txy_wr,
    input addr_t                 tk_wr,
    input logic [1:0]            done_q
);

    // R10
    reset_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (addr_o == '0 && !done_o));

    // R9
    start_clear_chk: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (x_val == '0 && k_val == '0 && !done_q[$past(ctx_sel_i)]));

    // R1
    x_step_chk: assert property (@(posedge clk) disable iff (rst)
        (step_i && !start_i && !wrap_x) |=> (x_val == $past(x_val) + addr_t'(WORD_WIDTH)));

    // R5
    wr_ctx_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (ctx_sel_i == 1'b0 && (step_i || start_i)) |=> ($stable(txy_wr) && $stable(tk_wr)));

    // R6
    mask_first_chk: assert property (@(posedge clk) disable iff (rst)
        (x_val < cfg_tile_x_i) |-> mask_o[0]);

    // R7
    tensor_in_tile_chk: assert property (@(posedge clk) disable iff (rst)
        tensor_last_o |-> tile_last_o);

    // R8
    rd_done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (done_q[0] && !(start_i && ctx_sel_i == 1'b0)) |=> done_q[0]);

endmodule

bind tile_addr_gen tag_addr_chk #(.WORD_WIDTH(WORD_WIDTH)) i_tag_addr_chk (
    .clk(clk), .rst(rst), .start_i(start_i), .step_i(step_i),
    .ctx_sel_i(ctx_sel_i), .cfg_tile_x_i(cfg_tile_x_i),
    .addr_o(addr_o), .mask_o(mask_o), .tile_last_o(tile_last_o),
    .tensor_last_o(tensor_last_o), .done_o(done_o),
    .x_val(x_val), .k_val(k_val), .wrap_x(wrap.x),
    .txy_wr(txy_ctx[1]), .tk_wr(tk_ctx[1]), .done_q(done_q)
);

// File: tb/test_tile_addr_gen.sv
module test_tile_addr_gen;
    import tag_pkg::*;

    localparam int WW = 4;

    logic clk = 1'b0;
    logic rst, start, step, sel;
    addr_t c_xy, c_k, c_ch, c_tx, c_mxy, c_mk;
    addr_t addr;
    logic [WW-1:0] mask;
    logic tile_last, tensor_last, done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    int e_addr[$], e_mask[$], e_tl[$], e_nl[$];
    int idx[2];
    int dn[2];

    always #4 clk = ~clk;

    tile_addr_gen #(.WORD_WIDTH(WW)) i_tile_addr_gen (
        .clk(clk), .rst(rst), .start_i(start), .step_i(step), .ctx_sel_i(sel),
        .cfg_tensor_xy_i(c_xy), .cfg_tensor_k_i(c_k), .cfg_tile_ch_i(c_ch),
        .cfg_tile_x_i(c_tx), .cfg_move_xy_i(c_mxy), .cfg_move_k_i(c_mk),
        .addr_o(addr), .mask_o(mask), .tile_last_o(tile_last),
        .tensor_last_o(tensor_last), .done_o(done)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // expected walk, written as the plain loop nest
    task automatic build();
        int xy, k, ch, tx, mxy, mk;
        xy = int'(c_xy); k = int'(c_k); ch = int'(c_ch);
        tx = int'(c_tx); mxy = int'(c_mxy); mk = int'(c_mk);
        e_addr.delete(); e_mask.delete(); e_tl.delete(); e_nl.delete();
        for (int tk = 0; tk < xy * k; tk += xy * mk)
            for (int txy = 0; txy < xy; txy += mxy)
                for (int kk = 0; kk < xy * ch; kk += xy)
                    for (int x = 0; x < tx; x += WW) begin
                        int m = 0;
                        int tl;
                        for (int i = 0; i < WW; i++)
                            if (x + i < tx) m |= (1 << i);
                        tl = ((x + WW >= tx) && (kk + xy >= xy * ch)) ? 1 : 0;
                        e_addr.push_back((x + kk + txy + tk) & 16'hFFFF);
                        e_mask.push_back(m);
                        e_tl.push_back(tl);
                        e_nl.push_back((tl == 1 && txy + mxy >= xy && tk + xy * mk >= xy * k) ? 1 : 0);
                    end
    endtask

    task automatic compare();
        int c, j;
        c = sel ? 1 : 0;
        j = idx[c];
        chk("R1/R2/R3/R4 addr", int'(addr), e_addr[j]);
        chk("R6 mask", int'(mask), e_mask[j]);
        chk("R7 tile_last", int'(tile_last), e_tl[j]);
        chk("R7 tensor_last", int'(tensor_last), e_nl[j]);
        chk("R8 done", int'(done), dn[c]);
    endtask

    task automatic cyc(logic st, logic sp, logic s);
        int c;
        @(negedge clk);
        start = st; step = sp; sel = s;
        #1 compare();
        @(posedge clk);
        c = s ? 1 : 0;
        if (st) begin
            idx[c] = 0; dn[c] = 0;
        end else if (sp) begin
            if (idx[c] == e_addr.size() - 1) begin
                idx[c] = 0; dn[c] = 1;
            end else begin
                idx[c]++;
            end
        end
    endtask

    task automatic run_tile(logic s, int words);
        for (int i = 0; i < words; i++) cyc(1'b0, 1'b1, s);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; start = 1'b0; step = 1'b0; sel = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        idx[0] = 0; idx[1] = 0; dn[0] = 0; dn[1] = 0;
        #1;
        chk("R10 reset addr", int'(addr), 0);
        chk("R10 reset done", int'(done), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int tw;
        rst = 1'b1; start = 1'b0; step = 1'b0; sel = 1'b0;
        // config A: tile_x not a word multiple, 4 words per tile, 4 tiles
        c_xy = 6; c_k = 4; c_ch = 2; c_tx = 5; c_mxy = 3; c_mk = 2;
        build();
        tw = 4;
        do_reset();
        cyc(1'b0, 1'b0, 1'b0);                 // R10 idle after reset
        cyc(1'b1, 1'b0, 1'b0);                 // R9 start read
        cyc(1'b1, 1'b0, 1'b1);                 // R9 start write
        run_tile(1'b0, tw);                    // read tile 0
        run_tile(1'b0, tw);                    // read tile 1 (R5 write kept)
        run_tile(1'b1, tw);                    // write tile 0
        cyc(1'b0, 1'b0, 1'b1);                 // hold while idle
        run_tile(1'b0, tw);                    // read tile 2
        run_tile(1'b1, tw);                    // write tile 1
        run_tile(1'b0, tw);                    // read tile 3 -> done R8
        cyc(1'b0, 1'b0, 1'b0);                 // R8 done visible
        run_tile(1'b1, tw);                    // write tile 2
        run_tile(1'b0, tw);                    // R8 stepping a done context keeps done
        run_tile(1'b1, tw);                    // write tile 3 -> done
        cyc(1'b0, 1'b0, 1'b1);
        cyc(1'b1, 1'b1, 1'b0);                 // R9 start wins over step
        cyc(1'b0, 1'b0, 1'b0);                 // R9 read back at origin, done clear
        cyc(1'b0, 1'b0, 1'b1);                 // R5 write context still done
        cyc(1'b0, 1'b1, 1'b0);                 // step read
        cyc(1'b1, 1'b1, 1'b0);                 // R9 start mid-tile with step
        run_tile(1'b0, tw);

        // config B: exact word fit, one channel per tile
        c_xy = 8; c_k = 2; c_ch = 1; c_tx = 8; c_mxy = 4; c_mk = 1;
        build();
        tw = 2;
        do_reset();
        for (int t = 0; t < 4; t++) begin
            run_tile(1'b0, tw);
            run_tile(1'b1, tw);
        end
        cyc(1'b0, 1'b0, 1'b0);
        cyc(1'b0, 1'b0, 1'b1);
        run_tile(1'b1, tw);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule